// File: doc/BRIEF.md
# Hardware Register Read Gate

This block answers read requests aimed at a small window of user-visible hardware registers, numbered 0 through 5. Each request carries a register number. The block also sees a privileged-mode flag and a 32-bit enable mask. If the requester is privileged, or if the mask bit for the requested number is set, the block returns the selected register value. Otherwise it reports a reserved-instruction exception and returns no data. Register numbers 6 and above always raise the exception.

The block does not store the register contents. They arrive as ports: the exception base register, the cache synchronisation step, the cycle counter, the counter resolution, performance counter 0 and a single configuration flag. Some of them are reshaped on the way out. The CPU number is cut from the low ten bits of the exception base, the 32-bit cycle counter is sign-extended, and the configuration flag is zero-extended. The response is registered and appears one clock after the request.

Top module: `hwreg_read_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rsp_ok`, `rsp_trap` and `rsp_data` are all zero.
- R2: In the cycle after `req_valid` is high, exactly one of `rsp_ok` and `rsp_trap` is high. In the cycle after `req_valid` is low, both are low and `rsp_data` is zero.
- R3: A request for a register number below 6 is granted (`rsp_ok`) when `priv_mode` is 1, or when bit `req_idx` of `enable_mask` is 1.
- R4: A request that is not granted raises `rsp_trap` with `rsp_data` equal to zero.
- R5: Register 0 returns bits [9:0] of `src_ebase`, zero-extended to DATA_W bits.
- R6: Register 1 returns `src_sync_step` unchanged. Register 3 returns `src_cyc_res` unchanged.
- R7: Register 2 returns the 32-bit `src_cycle`, sign-extended to DATA_W bits from its bit 31.
- R8: Register 4 returns `src_perf0` unchanged.
- R9: Register 5 returns `src_cfg_bit` in bit 0, with all other bits zero.
- R10: Any register number from 6 to 31 raises `rsp_trap`, even when `priv_mode` is 1 and the matching mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe, one request per high cycle |
| req_idx | input | 5 | Requested register number |
| priv_mode | input | 1 | Requester is privileged; bypasses the mask |
| enable_mask | input | 32 | Per-register user access enables, bit n for register n |
| src_ebase | input | 64 | Exception base register; low 10 bits form the CPU number |
| src_sync_step | input | 64 | Cache synchronisation step size |
| src_cycle | input | 32 | Cycle counter value |
| src_cyc_res | input | 64 | Cycle counter resolution |
| src_perf0 | input | 64 | Performance counter 0 |
| src_cfg_bit | input | 1 | Configuration flag |
| rsp_ok | output | 1 | Granted read; data valid |
| rsp_trap | output | 1 | Reserved-instruction exception |
| rsp_data | output | 64 | Read data; zero unless `rsp_ok` |

## Verification
All three outputs come from a single register stage. A request presented before clock edge k therefore shows its verdict and data right after edge k, with the values captured at that edge. The bench drives each request and the source values on the falling edge. On the next falling edge it compares the outputs with an expectation its model computed from those same inputs, so every result is checked exactly one cycle after its stimulus. The inputs change at that point, which shows that later source changes do not leak into a response already held.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

    localparam int NUM_HWR  = 6;
    localparam int CPUNUM_W = 10;
    localparam int CYC_W    = 32;

    typedef enum logic [2:0] {
        HWR_CPUNUM = 3'd0,
        HWR_STEP   = 3'd1,
        HWR_CYCLE  = 3'd2,
        HWR_CYCRES = 3'd3,
        HWR_PERF0  = 3'd4,
        HWR_CFGBIT = 3'd5
    } hwr_sel_e;

    typedef struct packed {
        logic ok;
        logic trap;
    } hwr_verdict_t;

endpackage

// File: rtl/hwr_access_check.sv
module hwr_access_check
    import hwr_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int MASK_W = 1 << IDX_W
) (
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              priv_mode,
    input  logic [MASK_W-1:0] enable_mask,
    output hwr_verdict_t      verdict
);

    logic in_range;
    logic permitted;

    always_comb begin
        in_range  = (int'(req_idx) < NUM_HWR);
        permitted = priv_mode | enable_mask[req_idx];
        verdict.ok   = req_valid & in_range & permitted;
        verdict.trap = req_valid & ~(in_range & permitted);
    end

endmodule

// File: rtl/hwr_value_mux.sv
module hwr_value_mux
    import hwr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] src_ebase,
    input  logic [DATA_W-1:0] src_sync_step,
    input  logic [CYC_W-1:0]  src_cycle,
    input  logic [DATA_W-1:0] src_cyc_res,
    input  logic [DATA_W-1:0] src_perf0,
    input  logic              src_cfg_bit,
    output logic [DATA_W-1:0] value
);

    localparam int EXT_W = DATA_W - CYC_W;

    hwr_sel_e sel;
    logic [DATA_W-1:0] cpunum_ext;
    logic [DATA_W-1:0] cycle_ext;
    logic [DATA_W-1:0] cfg_ext;

    generate
        if (EXT_W > 0) begin : g_wide
            assign cycle_ext = {{EXT_W{src_cycle[CYC_W-1]}}, src_cycle};
        end else begin : g_narrow
            assign cycle_ext = src_cycle[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        cpunum_ext = '0;
        cpunum_ext[CPUNUM_W-1:0] = src_ebase[CPUNUM_W-1:0];
        cfg_ext = '0;
        cfg_ext[0] = src_cfg_bit;
        sel = hwr_sel_e'(req_idx[2:0]);
        case (sel)
            HWR_CPUNUM: value = cpunum_ext;
            HWR_STEP:   value = src_sync_step;
            HWR_CYCLE:  value = cycle_ext;
            HWR_CYCRES: value = src_cyc_res;
            HWR_PERF0:  value = src_perf0;
            HWR_CFGBIT: value = cfg_ext;
            default:    value = '0;
        endcase
    end

endmodule

// File: rtl/hwr_resp_reg.sv
module hwr_resp_reg
    import hwr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  hwr_verdict_t      verdict,
    input  logic [DATA_W-1:0] value,
    output logic              rsp_ok,
    output logic              rsp_trap,
    output logic [DATA_W-1:0] rsp_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ok   <= 1'b0;
            rsp_trap <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_ok   <= verdict.ok;
            rsp_trap <= verdict.trap;
            rsp_data <= verdict.ok ? value : '0;
        end
    end

endmodule

// File: rtl/hwreg_read_gate.sv
module hwreg_read_gate
    import hwr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    localparam int MASK_W = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              priv_mode,
    input  logic [MASK_W-1:0] enable_mask,
    input  logic [DATA_W-1:0] src_ebase,
    input  logic [DATA_W-1:0] src_sync_step,
    input  logic [CYC_W-1:0]  src_cycle,
    input  logic [DATA_W-1:0] src_cyc_res,
    input  logic [DATA_W-1:0] src_perf0,
    input  logic              src_cfg_bit,
    output logic              rsp_ok,
    output logic              rsp_trap,
    output logic [DATA_W-1:0] rsp_data
);

    hwr_verdict_t      verdict;
    logic [DATA_W-1:0] value;

    hwr_access_check #(.IDX_W(IDX_W)) u_check (
        .req_valid   (req_valid),
        .req_idx     (req_idx),
        .priv_mode   (priv_mode),
        .enable_mask (enable_mask),
        .verdict     (verdict)
    );

    hwr_value_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
        .req_idx       (req_idx),
        .src_ebase     (src_ebase),
        .src_sync_step (src_sync_step),
        .src_cycle     (src_cycle),
        .src_cyc_res   (src_cyc_res),
        .src_perf0     (src_perf0),
        .src_cfg_bit   (src_cfg_bit),
        .value         (value)
    );

    hwr_resp_reg #(.DATA_W(DATA_W)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .value    (value),
        .rsp_ok   (rsp_ok),
        .rsp_trap (rsp_trap),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/hwreg_read_gate_chk.sv
module hwreg_read_gate_chk
    import hwr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    localparam int MASK_W = 1 << IDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_idx,
    input logic              priv_mode,
    input logic [MASK_W-1:0] enable_mask,
    input logic [CYC_W-1:0]  src_cycle,
    input logic              rsp_ok,
    input logic              rsp_trap,
    input logic [DATA_W-1:0] rsp_data
);

    // R2: never both verdicts at once
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_ok, rsp_trap}));

    // R2: every request answered next cycle
    a_r2_answered: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok || rsp_trap));

    // R2: no request, no response
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_ok && !rsp_trap && rsp_data == '0));

    // R4: trap carries no data
    a_r4_trap_no_data: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_data == '0));

    // R3: privileged in-range read granted
    a_r3_priv_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv_mode && int'(req_idx) < NUM_HWR) |=> rsp_ok);

    // R3: masked user read granted
    a_r3_mask_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enable_mask[req_idx] && int'(req_idx) < NUM_HWR) |=> rsp_ok);

    // R10: high numbers always trap
    a_r10_high_trap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_idx) >= NUM_HWR) |=> rsp_trap);

    // R7: cycle counter sign extension
    a_r7_cycle_sext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv_mode && req_idx == IDX_W'(2)) |=>
        (rsp_data == {{(DATA_W-CYC_W){$past(src_cycle[CYC_W-1])}}, $past(src_cycle)}));

endmodule

bind hwreg_read_gate hwreg_read_gate_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_idx     (req_idx),
    .priv_mode   (priv_mode),
    .enable_mask (enable_mask),
    .src_cycle   (src_cycle),
    .rsp_ok      (rsp_ok),
    .rsp_trap    (rsp_trap),
    .rsp_data    (rsp_data)
);

// File: tb/hwreg_read_gate_tb_top.sv
module hwreg_read_gate_tb_top;

    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_idx = '0;
    logic        priv_mode = 1'b0;
    logic [31:0] enable_mask = '0;
    logic [63:0] src_ebase = '0;
    logic [63:0] src_sync_step = '0;
    logic [31:0] src_cycle = '0;
    logic [63:0] src_cyc_res = '0;
    logic [63:0] src_perf0 = '0;
    logic        src_cfg_bit = 1'b0;
    logic        rsp_ok;
    logic        rsp_trap;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;

    logic        exp_ok;
    logic        exp_trap;
    logic [63:0] exp_data;
    string       exp_tag;

    always #5 clk = ~clk;

    hwreg_read_gate dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .priv_mode(priv_mode), .enable_mask(enable_mask),
        .src_ebase(src_ebase), .src_sync_step(src_sync_step),
        .src_cycle(src_cycle), .src_cyc_res(src_cyc_res),
        .src_perf0(src_perf0), .src_cfg_bit(src_cfg_bit),
        .rsp_ok(rsp_ok), .rsp_trap(rsp_trap), .rsp_data(rsp_data)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    // Behavioural model: expectation from the inputs now driven
    task automatic model();
        int  n;
        bit  allowed;
        n = int'(req_idx);
        allowed = (n < 6) && (priv_mode || enable_mask[n]);
        exp_ok = 0; exp_trap = 0; exp_data = 0;
        if (!req_valid) begin
            exp_tag = "R2";
        end else if (!allowed) begin
            exp_trap = 1;
            exp_tag = (n >= 6) ? "R10" : "R4";
        end else begin
            exp_ok = 1;
            case (n)
                0: begin exp_data = 64'(src_ebase % 1024); exp_tag = "R5"; end
                1: begin exp_data = src_sync_step; exp_tag = "R6"; end
                2: begin exp_data = 64'(signed'(src_cycle)); exp_tag = "R7"; end
                3: begin exp_data = src_cyc_res; exp_tag = "R6"; end
                4: begin exp_data = src_perf0; exp_tag = "R8"; end
                default: begin exp_data = src_cfg_bit ? 64'd1 : 64'd0; exp_tag = "R9"; end
            endcase
            if (!priv_mode) exp_tag = {exp_tag, "/R3"};
        end
    endtask

    task automatic compare();
        checks++;
        if (rsp_ok !== exp_ok || rsp_trap !== exp_trap || rsp_data !== exp_data) begin
            errors++;
            $display("FAIL %s: actual ok=%0b trap=%0b data=%h expected ok=%0b trap=%0b data=%h",
                     exp_tag, rsp_ok, rsp_trap, rsp_data, exp_ok, exp_trap, exp_data);
        end
    endtask

    task automatic scramble_sources();
        src_ebase     = {$urandom, $urandom};
        src_sync_step = {$urandom, $urandom};
        src_cycle     = $urandom;
        src_cyc_res   = {$urandom, $urandom};
        src_perf0     = {$urandom, $urandom};
        src_cfg_bit   = 1'($urandom);
    endtask

    // Drive at a falling edge, check one cycle later at the next falling edge
    task automatic issue(input bit v, input int idx, input bit pm, input logic [31:0] m);
        req_valid = v; req_idx = 5'(idx); priv_mode = pm; enable_mask = m;
        model();
        @(negedge clk);
        compare();
        scramble_sources();
    endtask

    initial begin
        scramble_sources();
        req_valid = 1; req_idx = 5'd1; priv_mode = 1;
        repeat (3) @(negedge clk);
        // R1: reset state despite an active request
        exp_ok = 0; exp_trap = 0; exp_data = 0; exp_tag = "R1";
        compare();
        rst = 0; req_valid = 0;
        @(negedge clk);
        exp_tag = "R1";
        compare();

        // Privileged reads of every register (R3, R5..R9)
        for (int i = 0; i < 6; i++) issue(1, i, 1, 32'h0);
        // Sign extension both ways (R7)
        src_cycle = 32'h8000_0001; issue(1, 2, 1, 32'h0);
        src_cycle = 32'h7FFF_FFFF; issue(1, 2, 1, 32'h0);
        // Config bit both values (R9)
        src_cfg_bit = 1; issue(1, 5, 1, 32'h0);
        src_cfg_bit = 0; issue(1, 5, 1, 32'h0);
        // CPU number slice (R5)
        src_ebase = 64'hFFFF_FFFF_FFFF_FFFF; issue(1, 0, 0, 32'h1);
        // User reads with single mask bits: grant on own bit, trap otherwise (R3, R4)
        for (int i = 0; i < 6; i++) begin
            issue(1, i, 0, 32'h1 << i);
            issue(1, i, 0, ~(32'h1 << i));
        end
        // High numbers trap even with privilege and full mask (R10)
        for (int i = 6; i < 32; i++) issue(1, i, 1, 32'hFFFF_FFFF);
        // Idle cycles produce nothing (R2)
        issue(0, 2, 1, 32'hFFFF_FFFF);
        issue(0, 7, 0, 32'h0);
        // Random traffic, back to back (R2, R3, R4)
        for (int k = 0; k < 2000; k++)
            issue(1'($urandom % 4 != 0), int'($urandom % 8), 1'($urandom),
                  $urandom);
        // Reset mid-stream (R1)
        req_valid = 1; req_idx = 5'd4; priv_mode = 1;
        rst = 1;
        @(negedge clk);
        exp_ok = 0; exp_trap = 0; exp_data = 0; exp_tag = "R1";
        compare();
        rst = 0;
        issue(1, 4, 1, 32'h0);
        finish_run();
    end

endmodule